// File: doc/BRIEF.md
# Serial-IRQ status latch controller

This block holds the interrupt status and mask state of a low-pin-count host controller. Sixteen level-sensitive device interrupt lines come in. Each one that is seen high sets a sticky status bit. Software acknowledges a bit by writing a one to it, but the acknowledge only takes effect when that line has already dropped, so a device that still requests service cannot lose its interrupt. An optional auto-clear mode instead drops a status bit on its own as soon as the line falls.

The status is gated by a mask register and by a global enable in the control register. The result is a registered active vector, plus a single OR-reduced interrupt output for the downstream interrupt controller. A 32-bit register port with a valid, a write flag, an address and write data reaches the control, mask, status, error-address and two firmware-access registers. Read data returns combinationally for the address currently presented. The serial wire protocol and any routing of the active vector lie outside the block.

Top module: `sirq_status_ctrl`

## Requirements
- R1: After reset, control, mask, status, firmware segment select and error address read 0, the firmware read-size register reads 0x02000000, and active_vec and irq_out are 0.
- R2: Device interrupt n maps to status bit 31-n (interrupt 0 is bit 31, interrupt 15 is bit 16). A clock edge that samples dev_irq[n] high sets that bit, and the bit stays set after the line falls while auto-clear is off.
- R3: A write to the status register (offset 0x38) clears every status bit written as 1 whose line is low at that edge. Bits written as 0 are unchanged.
- R4: A write-one-to-clear is ignored for any line that is still high at the writing edge.
- R5: While control bit 31 is 0, active_vec is all zero. While it is 1, active_vec bit n equals status bit 31-n AND mask bit 31-n. The mask lives at offset 0x34 and uses the same bit layout as status.
- R6: With control bit 23 set, a line sampled high at one edge and low at the next has its status bit cleared at that second edge, without any write.
- R7: The control register (offset 0x30) stores bit 31 (enable), bit 30 (quiet mode), bits 25:24 (start-frame width code: 00 = 4 clocks, 01 = 6, 10 = 8) and bit 23 (auto-clear). It reads these back, and every other control bit reads 0.
- R8: The firmware segment/ID select register (offset 0x24) and the firmware read-size register (offset 0x28) store and read back all 32 bits.
- R9: A read of any offset other than 0x24, 0x28, 0x30, 0x34, 0x38 or 0x40 returns 0xFFFFFFFF. The error-address register (offset 0x40) is read-only and writes to it leave it at 0.
- R10: active_vec and irq_out are registered. They change at the same clock edge that captures a register write or a dev_irq change, and irq_out is the OR of active_vec.
- R11: Mask and status bits 15:0 read 0 whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | NUM_IRQ | Level device interrupt lines, bit n is interrupt n |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| active_vec | output | NUM_IRQ | Registered enabled-and-masked status, bit n is interrupt n |
| irq_out | output | 1 | Registered OR of active_vec |

## Verification
The bench builds the block with its default parameters: 16 interrupt lines, a 32-bit data path and an 8-bit offset. With these values both ends of the interrupt-to-bit mapping are reachable (interrupt 0 at bit 31, interrupt 15 at bit 16), as are the reserved low half of mask and status and unused offsets on both sides of the implemented ones. It drives mixed line patterns against the acknowledge, the auto-clear and the mask/enable gating. It also checks the active outputs exactly one edge after each write or line change.

// File: rtl/lpc_sirq_pkg.sv
package lpc_sirq_pkg;

  // Register byte offsets (decoded by software drivers, so they are fixed)
  localparam logic [7:0] OFS_FW_SEL  = 8'h24;
  localparam logic [7:0] OFS_FW_SIZE = 8'h28;
  localparam logic [7:0] OFS_CTRL    = 8'h30;
  localparam logic [7:0] OFS_MASK    = 8'h34;
  localparam logic [7:0] OFS_STAT    = 8'h38;
  localparam logic [7:0] OFS_ERRADR  = 8'h40;

  // Control register field positions
  localparam int CTL_EN_BIT    = 31;
  localparam int CTL_QUIET_BIT = 30;
  localparam int CTL_START_HI  = 25;
  localparam int CTL_START_LO  = 24;
  localparam int CTL_AUTO_BIT  = 23;

  // Reset value of the firmware read-size register (4-byte access)
  localparam logic [31:0] FW_SIZE_RST = 32'h0200_0000;

  // Status/mask bit that carries device interrupt idx
  function automatic int irq_bit(input int dw, input int idx);
    return dw - 1 - idx;
  endfunction

  // Control bits that hold state; all others read back as zero
  function automatic logic [31:0] ctrl_keep_mask();
    logic [31:0] m;
    m = '0;
    m[CTL_EN_BIT]    = 1'b1;
    m[CTL_QUIET_BIT] = 1'b1;
    m[CTL_START_HI]  = 1'b1;
    m[CTL_START_LO]  = 1'b1;
    m[CTL_AUTO_BIT]  = 1'b1;
    return m;
  endfunction

  // Start-frame width in clocks for a width code
  function automatic int start_frame_clocks(input logic [1:0] code);
    case (code)
      2'b00:   return 4;
      2'b01:   return 6;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/sirq_status_latch.sv
module sirq_status_latch #(
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] dev_irq,
  input  logic [NUM_IRQ-1:0] w1c_req,
  input  logic               auto_en,
  output logic [NUM_IRQ-1:0] stat_q,
  output logic [NUM_IRQ-1:0] stat_nxt,
  output logic [NUM_IRQ-1:0] line_fell,
  output logic [NUM_IRQ-1:0] clr_hit
);

  logic [NUM_IRQ-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      stat_q <= '0;
    end else begin
      line_q <= dev_irq;
      stat_q <= stat_nxt;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    // Named per-bit events for the checks below
    assign line_fell[i] = line_q[i] & ~dev_irq[i];
    assign clr_hit[i]   = (w1c_req[i] & ~dev_irq[i]) | (auto_en & line_fell[i]);
    assign stat_nxt[i]  = (stat_q[i] | dev_irq[i]) & ~clr_hit[i];

    // R2: a sampled-high line leaves its status bit set
    assert_set_on_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dev_irq[i] |=> stat_q[i]);

    // R2: without a clear request or auto-clear, a set bit holds
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !w1c_req[i] && !auto_en) |=> stat_q[i]);

    // R3: acknowledge of a low line clears the bit
    assert_w1c_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c_req[i] && !dev_irq[i]) |=> !stat_q[i]);

    // R4: acknowledge of a high line is ignored
    assert_w1c_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c_req[i] && dev_irq[i]) |=> stat_q[i]);

    // R6: auto-clear drops the bit on a falling line
    assert_autoclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && line_fell[i]) |=> !stat_q[i]);
  end

endmodule

// File: rtl/sirq_reg_bank.sv
module sirq_reg_bank
  import lpc_sirq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_IRQ-1:0] stat_q,
  output logic [DATA_W-1:0]  ctrl_q,
  output logic [DATA_W-1:0]  ctrl_nxt,
  output logic [NUM_IRQ-1:0] mask_q,
  output logic [NUM_IRQ-1:0] mask_nxt,
  output logic [NUM_IRQ-1:0] w1c_req,
  output logic [DATA_W-1:0]  rdata
);

  localparam logic [DATA_W-1:0] KEEP = DATA_W'(ctrl_keep_mask());

  logic [DATA_W-1:0] fw_sel_q, fw_size_q;
  logic [DATA_W-1:0] stat_view, mask_view;
  logic hit_ctrl, hit_mask, hit_stat, hit_sel, hit_size;

  // Write decode, exposed as named strobes
  assign hit_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign hit_mask = wr_en && (addr == ADDR_W'(OFS_MASK));
  assign hit_stat = wr_en && (addr == ADDR_W'(OFS_STAT));
  assign hit_sel  = wr_en && (addr == ADDR_W'(OFS_FW_SEL));
  assign hit_size = wr_en && (addr == ADDR_W'(OFS_FW_SIZE));

  assign ctrl_nxt = hit_ctrl ? (wdata & KEEP) : ctrl_q;

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      mask_nxt[i] = hit_mask ? wdata[irq_bit(DATA_W, i)] : mask_q[i];
      w1c_req[i]  = hit_stat & wdata[irq_bit(DATA_W, i)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      mask_q    <= '0;
      fw_sel_q  <= '0;
      fw_size_q <= DATA_W'(FW_SIZE_RST);
    end else begin
      ctrl_q <= ctrl_nxt;
      mask_q <= mask_nxt;
      if (hit_sel)  fw_sel_q  <= wdata;
      if (hit_size) fw_size_q <= wdata;
    end
  end

  // Register layout of status and mask: interrupt i at bit DATA_W-1-i
  always_comb begin
    stat_view = '0;
    mask_view = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      stat_view[irq_bit(DATA_W, i)] = stat_q[i];
      mask_view[irq_bit(DATA_W, i)] = mask_q[i];
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(OFS_FW_SEL):  rdata = fw_sel_q;
      ADDR_W'(OFS_FW_SIZE): rdata = fw_size_q;
      ADDR_W'(OFS_CTRL):    rdata = ctrl_q;
      ADDR_W'(OFS_MASK):    rdata = mask_view;
      ADDR_W'(OFS_STAT):    rdata = stat_view;
      ADDR_W'(OFS_ERRADR):  rdata = '0;
      default:              rdata = '1;
    endcase
  end

  // R8: firmware registers change only on their own write
  assert_fw_size_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_size |=> $stable(fw_size_q));
  assert_fw_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_sel |=> $stable(fw_sel_q));

  // R7: a control write that is not to the control offset leaves it intact
  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_ctrl |=> $stable(ctrl_q));

endmodule

// File: rtl/sirq_active_gen.sv
module sirq_active_gen #(
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] stat_nxt,
  input  logic [NUM_IRQ-1:0] mask_nxt,
  input  logic               en_nxt,
  input  logic [NUM_IRQ-1:0] stat_q,
  input  logic [NUM_IRQ-1:0] mask_q,
  input  logic               en_q,
  output logic [NUM_IRQ-1:0] active_q,
  output logic               irq_q
);

  logic [NUM_IRQ-1:0] active_nxt;

  // Computed from next-state values so outputs land on the capturing edge
  assign active_nxt = en_nxt ? (stat_nxt & mask_nxt) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      active_q <= active_nxt;
      irq_q    <= |active_nxt;
    end
  end

  // R5: disabled means nothing active
  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (active_q == '0));

  // R5, R10: registered output agrees with the registered state
  assert_active_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (active_q == (stat_q & mask_q)));

  // R10: summary line tracks the vector
  assert_irq_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (active_q != '0));

endmodule

// File: rtl/sirq_status_ctrl.sv
module sirq_status_ctrl
  import lpc_sirq_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] dev_irq,
  input  logic               reg_valid,
  input  logic               reg_write,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_IRQ-1:0] active_vec,
  output logic               irq_out
);

  logic               wr_en;
  logic [DATA_W-1:0]  ctrl_q, ctrl_nxt;
  logic [NUM_IRQ-1:0] mask_q, mask_nxt, w1c_req;
  logic [NUM_IRQ-1:0] stat_q, stat_nxt, line_fell, clr_hit;

  assign wr_en = reg_valid && reg_write;

  sirq_reg_bank #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NUM_IRQ (NUM_IRQ)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .stat_q   (stat_q),
    .ctrl_q   (ctrl_q),
    .ctrl_nxt (ctrl_nxt),
    .mask_q   (mask_q),
    .mask_nxt (mask_nxt),
    .w1c_req  (w1c_req),
    .rdata    (reg_rdata)
  );

  sirq_status_latch #(
    .NUM_IRQ (NUM_IRQ)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_irq   (dev_irq),
    .w1c_req   (w1c_req),
    .auto_en   (ctrl_q[CTL_AUTO_BIT]),
    .stat_q    (stat_q),
    .stat_nxt  (stat_nxt),
    .line_fell (line_fell),
    .clr_hit   (clr_hit)
  );

  sirq_active_gen #(
    .NUM_IRQ (NUM_IRQ)
  ) u_active (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_nxt (stat_nxt),
    .mask_nxt (mask_nxt),
    .en_nxt   (ctrl_nxt[CTL_EN_BIT]),
    .stat_q   (stat_q),
    .mask_q   (mask_q),
    .en_q     (ctrl_q[CTL_EN_BIT]),
    .active_q (active_vec),
    .irq_q    (irq_out)
  );

  // R3/R4/R6: a clear never hits a line that is high at that edge
  assert_clear_only_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit & dev_irq) == '0);

  // R6: auto-clear off means falling lines clear nothing on their own
  assert_no_autoclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CTL_AUTO_BIT] && w1c_req == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

endmodule

// File: tb/sirq_status_ctrl_test.sv
module sirq_status_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dev_irq = '0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] active_vec;
  logic        irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_out;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  sirq_status_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_irq    (dev_irq),
    .reg_valid  (reg_valid),
    .reg_write  (reg_write),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .active_vec (active_vec),
    .irq_out    (irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench-side layout: interrupt n sits at register bit 31-n
  function automatic logic [31:0] to_reg(input logic [15:0] v);
    logic [31:0] r = '0;
    for (int n = 0; n < 16; n++) if (v[n]) r = r | (32'h8000_0000 >> n);
    return r;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    it.is_out = 1'b0; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chk_out(input logic [15:0] act, input string tag);
    item_t it;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    it.is_out = 1'b1; it.exp = {15'd0, act, (act != 16'd0)}; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic set_irq(input logic [15:0] v);
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; dev_irq = v;
  endtask

  // Monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = sb.pop_front();
        got = it.is_out ? {15'd0, active_vec, irq_out} : reg_rdata;
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h30, 32'h0, "R1 ctrl");
    rd(8'h34, 32'h0, "R1 mask");
    rd(8'h38, 32'h0, "R1 status");
    rd(8'h28, 32'h0200_0000, "R1 fw size");
    rd(8'h24, 32'h0, "R1 fw sel");
    rd(8'h40, 32'h0, "R1 err addr");
    chk_out(16'h0, "R1 outputs");

    // R7 control fields
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, 32'hC380_0000, "R7 ctrl all ones");
    wr(8'h30, 32'h4100_0000);
    rd(8'h30, 32'h4100_0000, "R7 quiet 6clk");
    wr(8'h30, 32'h0200_0000);
    rd(8'h30, 32'h0200_0000, "R7 8clk");

    // R8 firmware registers
    wr(8'h28, 32'h0700_0000);
    rd(8'h28, 32'h0700_0000, "R8 fw size");
    wr(8'h24, 32'h1234_5678);
    rd(8'h24, 32'h1234_5678, "R8 fw sel");

    // R9 unimplemented offsets and read-only error address
    rd(8'h00, 32'hFFFF_FFFF, "R9 offset 00");
    rd(8'h2C, 32'hFFFF_FFFF, "R9 offset 2C");
    rd(8'h3C, 32'hFFFF_FFFF, "R9 offset 3C");
    rd(8'hFC, 32'hFFFF_FFFF, "R9 offset FC");
    wr(8'h40, 32'hDEAD_BEEF);
    rd(8'h40, 32'h0, "R9 err addr read-only");

    // R11 mask low half reserved
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, 32'hFFFF_0000, "R11 mask low bits");

    // R2 latch and stickiness, R10 one-edge latency
    wr(8'h30, 32'h8000_0000);
    set_irq(16'h0008);
    chk_out(16'h0008, "R10 active after input edge");
    rd(8'h38, to_reg(16'h0008), "R2 irq3 at bit 28");
    set_irq(16'h0000);
    rd(8'h38, 32'h1000_0000, "R2 sticky after fall");

    // R3 acknowledge of a low line
    wr(8'h38, 32'h1000_0000);
    rd(8'h38, 32'h0, "R3 cleared");
    chk_out(16'h0, "R3 outputs cleared");

    // R4 acknowledge ignored while high
    set_irq(16'h8001);
    rd(8'h38, 32'h8001_0000, "R2 irq0 msb irq15 bit16");
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, 32'h8001_0000, "R4 w1c ignored while high");
    set_irq(16'h8000);
    wr(8'h38, 32'h8001_0000);
    rd(8'h38, 32'h0001_0000, "R4 only low line cleared");
    rd(8'h38, 32'h0001_0000, "R11 status low bits");

    // R5 mask and enable gating, R10 latency after writes
    wr(8'h34, 32'h0001_0000);
    chk_out(16'h8000, "R5 mask irq15 only");
    wr(8'h34, 32'h0000_0000);
    chk_out(16'h0000, "R5 all masked");
    wr(8'h34, 32'hFFFF_0000);
    chk_out(16'h8000, "R5 unmasked");
    wr(8'h30, 32'h0000_0000);
    chk_out(16'h0000, "R5 disabled");
    rd(8'h38, 32'h0001_0000, "R5 status kept when disabled");

    // R6 auto-clear
    wr(8'h30, 32'h8080_0000);
    chk_out(16'h8000, "R5 re-enabled");
    set_irq(16'h0000);
    rd(8'h38, 32'h0, "R6 auto-clear on fall");
    chk_out(16'h0000, "R6 outputs after auto-clear");
    set_irq(16'hA5A5);
    chk_out(16'hA5A5, "R5 pattern active");
    rd(8'h38, to_reg(16'hA5A5), "R2 pattern status");
    set_irq(16'h0000);
    rd(8'h38, 32'h0, "R6 pattern auto-cleared");
    chk_out(16'h0000, "R6 pattern outputs");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule